// File: doc/BRIEF.md
# Timestamp Clock Phase Adjuster

This block corrects the phase of a local time-of-day counter. The counter holds a seconds field and a nanoseconds field, and advances by a fixed nominal increment on every clock. A host may write one command that names a count of unit steps, the unit (one nanosecond or one second) and, for nanoseconds, the direction. The block then meters those steps into the counter one at a time. A single write therefore does the work of many single-step writes.

A spacing register sets how many clocks lie between steps. A wide spacing spreads a large correction thinly, so that the extra jitter touches only a small fraction of cycles. The spacing value is captured when the command is accepted. When the count runs out, the block drops its busy flag and raises a sticky done flag, which the host clears by writing a one to it. The counter is built into the block so that the effect of the correction can be seen at the ports.

Top module: `ts_phase_adjuster`

## Requirements
- R1: After reset, the seconds and nanoseconds outputs are 0, active_o and done_o are 0, and no step output is high.
- R2: With no adjustment running, the nanoseconds field grows by NOM_INC on each clock. It wraps at ROLL_NS, and each wrap adds one to the seconds field.
- R3: A write to address 0 is a command with these fields: bits [15:0] count, bit 16 unit (0 = ns, 1 = s), bit 17 direction (1 = subtract) and bit 31 start. A start with count D>0 moves the time by exactly D units in total.
- R4: In a clock that carries a nanosecond step, the nanoseconds field grows by NOM_INC+1 when adding and by NOM_INC-1 when subtracting.
- R5: Second-unit steps always add one second each, whatever the direction bit holds.
- R6: A spacing value of 0 or 1 (address 1, bits [15:0]) gives one step per clock, so active_o stays high for D clocks.
- R7: A spacing value of N>1 gives one step every N clocks, so active_o stays high for D*N clocks.
- R8: The spacing in force is the value held at the start write. A spacing write during a run does not change that run.
- R9: At the clock edge that applies the last step, active_o falls and done_o rises.
- R10: done_o is sticky. It is cleared only by a write to address 2 with bit 0 set. A new start does not clear it.
- R11: A command write during a run abandons the run after the steps already applied. A write with start=1 begins the new command. A write with start=0 leaves the block idle and does not set done_o.
- R12: A start with count 0 sets done_o on the next edge, applies no step and never raises active_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timestamp clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 command, 1 spacing, 2 status) |
| wr_data_i | input | 32 | Register write data |
| active_o | output | 1 | Adjustment in progress |
| done_o | output | 1 | Sticky completion flag |
| step_up_o | output | 1 | A one-unit forward step is applied this clock |
| step_dn_o | output | 1 | A one-nanosecond backward step is applied this clock |
| step_sec_o | output | 1 | The current step is in seconds |
| sec_o | output | SEC_W | Seconds field of the time counter |
| ns_o | output | NS_W | Nanoseconds field of the time counter |

## Verification
A wrong remaining count or a wrong spacing counter does not show in the time outputs at once. It shows as an active_o window of the wrong length, and the bench measures that window to the clock. It also shows as a net time offset once the run ends, when the bench compares the counter against NOM_INC times the elapsed clocks plus the corrections it expects. A direction or unit mix-up shows as a per-clock nanosecond delta other than NOM_INC±1, or as a second-sized error, by the first clock after the run ends. Wrap and carry faults show within one wrap period. The bench shortens ROLL_NS so that this period is a few thousand clocks.

// File: rtl/phase_adj_pkg.sv
package phase_adj_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int DELTA_W  = 16;
  localparam int UNIT_BIT = 16;
  localparam int DIR_BIT  = 17;
  localparam int ACT_BIT  = 31;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CYC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic               act;
    logic               dec;
    logic               unit_sec;
    logic [DELTA_W-1:0] delta;
  } adj_cmd_t;
endpackage

// File: rtl/phase_adj_regs.sv
module phase_adj_regs
  import phase_adj_pkg::*;
#(
  parameter int CYC_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    done_set_i,
  output logic                    cmd_wr_o,
  output adj_cmd_t                cmd_o,
  output logic [CYC_W-1:0]        cyc_o,
  output logic                    done_o
);
  logic cyc_wr, done_clr, done_q;
  logic unused_data;

  assign unused_data = ^wr_data_i;
  assign cmd_wr_o = wr_en_i && (wr_addr_i == ADDR_CMD);
  assign cyc_wr   = wr_en_i && (wr_addr_i == ADDR_CYC);
  assign done_clr = wr_en_i && (wr_addr_i == ADDR_STAT) && wr_data_i[0];

  assign cmd_o.act      = wr_data_i[ACT_BIT];
  assign cmd_o.dec      = wr_data_i[DIR_BIT];
  assign cmd_o.unit_sec = wr_data_i[UNIT_BIT];
  assign cmd_o.delta    = wr_data_i[DELTA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cyc_wr) cyc_o <= wr_data_i[CYC_W-1:0];
      if (done_set_i)    done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end
  assign done_o = done_q;

  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !done_clr |=> done_q);
endmodule

// File: rtl/phase_adj_seq.sv
module phase_adj_seq
  import phase_adj_pkg::*;
#(
  parameter int CYC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  adj_cmd_t          cmd_i,
  input  logic [CYC_W-1:0]  cyc_i,
  output logic              active_o,
  output logic              done_set_o,
  output logic              ns_up_o,
  output logic              ns_dn_o,
  output logic              sec_up_o
);
  logic               active_q, unit_q, dec_q, step;
  logic [DELTA_W-1:0] remain_q;
  logic [CYC_W-1:0]   per_q, cnt_q, per_eff;
  logic               last_step, zero_start;

  // spacing of 0 behaves as 1
  assign per_eff    = (cyc_i == '0) ? CYC_W'(1) : cyc_i;
  assign step       = active_q && (cnt_q == '0);
  assign last_step  = step && (remain_q == DELTA_W'(1));
  assign zero_start = cmd_wr_i && cmd_i.act && (cmd_i.delta == '0);
  assign done_set_o = (last_step && !cmd_wr_i) || zero_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      unit_q   <= 1'b0;
      dec_q    <= 1'b0;
      remain_q <= '0;
      per_q    <= '0;
      cnt_q    <= '0;
    end else if (cmd_wr_i) begin
      active_q <= cmd_i.act && (cmd_i.delta != '0);
      unit_q   <= cmd_i.unit_sec;
      dec_q    <= cmd_i.dec;
      remain_q <= cmd_i.delta;
      per_q    <= per_eff;
      cnt_q    <= per_eff - CYC_W'(1);
    end else if (step) begin
      remain_q <= remain_q - DELTA_W'(1);
      cnt_q    <= per_q - CYC_W'(1);
      if (last_step) active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q - CYC_W'(1);
    end
  end

  assign active_o = active_q;
  assign ns_up_o  = step && !unit_q && !dec_q;
  assign ns_dn_o  = step && !unit_q && dec_q;
  assign sec_up_o = step && unit_q;

  // R9
  last_step_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_step && !cmd_wr_i |=> !active_q);
  // R7
  step_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && (per_q > CYC_W'(1)) && !cmd_wr_i |=> !step);
  // R12
  zero_delta_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_start |=> !active_q);
  // R3
  one_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ns_up_o, ns_dn_o, sec_up_o}));
endmodule

// File: rtl/phase_adj_tod.sv
module phase_adj_tod #(
  parameter int unsigned ROLL_NS = 1_000_000_000,
  parameter int unsigned NOM_INC = 40,
  parameter int          SEC_W   = 32,
  localparam int         NS_W    = $clog2(ROLL_NS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ns_up_i,
  input  logic              ns_dn_i,
  input  logic              sec_up_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o
);
  localparam logic [NS_W:0] ROLL_W = (NS_W+1)'(ROLL_NS);
  localparam logic [NS_W:0] NOM_W  = (NS_W+1)'(NOM_INC);

  logic [NS_W:0]    inc, sum;
  logic             carry;
  logic [SEC_W-1:0] sec_q;
  logic [NS_W-1:0]  ns_q;

  always_comb begin
    inc = NOM_W;
    if (ns_up_i) inc = NOM_W + (NS_W+1)'(1);
    if (ns_dn_i) inc = NOM_W - (NS_W+1)'(1);
    sum   = {1'b0, ns_q} + inc;
    carry = (sum >= ROLL_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      ns_q  <= carry ? NS_W'(sum - ROLL_W) : NS_W'(sum);
      sec_q <= sec_q + SEC_W'(carry) + SEC_W'(sec_up_i);
    end
  end

  assign sec_o = sec_q;
  assign ns_o  = ns_q;

  // R2
  ns_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, ns_q} < ROLL_W);
  // R5
  sec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_up_i |=> (sec_q - $past(sec_q)) >= SEC_W'(1));
endmodule

// File: rtl/ts_phase_adjuster.sv
module ts_phase_adjuster
  import phase_adj_pkg::*;
#(
  parameter int unsigned ROLL_NS = 1_000_000_000,
  parameter int unsigned NOM_INC = 40,
  parameter int          SEC_W   = 32,
  parameter int          CYC_W   = 16,
  localparam int         NS_W    = $clog2(ROLL_NS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              active_o,
  output logic              done_o,
  output logic              step_up_o,
  output logic              step_dn_o,
  output logic              step_sec_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [NS_W-1:0]   ns_o
);
  adj_cmd_t         cmd;
  logic             cmd_wr, done_set, ns_up, ns_dn, sec_up;
  logic [CYC_W-1:0] cyc;

  phase_adj_regs #(.CYC_W(CYC_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .done_set_i(done_set), .cmd_wr_o(cmd_wr), .cmd_o(cmd),
    .cyc_o(cyc), .done_o(done_o)
  );

  phase_adj_seq #(.CYC_W(CYC_W)) i_seq (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_i(cmd), .cyc_i(cyc),
    .active_o(active_o), .done_set_o(done_set),
    .ns_up_o(ns_up), .ns_dn_o(ns_dn), .sec_up_o(sec_up)
  );

  phase_adj_tod #(.ROLL_NS(ROLL_NS), .NOM_INC(NOM_INC), .SEC_W(SEC_W)) i_tod (
    .clk_i, .rst_ni, .ns_up_i(ns_up), .ns_dn_i(ns_dn), .sec_up_i(sec_up),
    .sec_o(sec_o), .ns_o(ns_o)
  );

  assign step_up_o  = ns_up | sec_up;
  assign step_dn_o  = ns_dn;
  assign step_sec_o = sec_up;

  // R1
  idle_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !(step_up_o || step_dn_o));
endmodule

// File: tb/test_ts_phase_adjuster.sv
module test_ts_phase_adjuster;
  localparam int unsigned ROLL = 100_000;
  localparam int unsigned NOM  = 40;
  localparam int NS_W = $clog2(ROLL);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic active_o, done_o, step_up_o, step_dn_o, step_sec_o;
  logic [31:0] sec_o;
  logic [NS_W-1:0] ns_o;

  int vectors = 0, errs = 0;
  longint ticks = 0, adj = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz
  always @(posedge clk_i) if (rst_ni) ticks <= ticks + 1;

  ts_phase_adjuster #(.ROLL_NS(ROLL), .NOM_INC(NOM)) i_ts_phase_adjuster (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint exp_total();
    return ticks * NOM + adj;
  endfunction

  task automatic check_time(input string req);
    longint t = exp_total();
    check(sec_o == 32'(t / ROLL), req, longint'(sec_o), t / ROLL);
    check(longint'(ns_o) == t % ROLL, req, longint'(ns_o), t % ROLL);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [31:0] cmd(input int d, input bit u, input bit dn, input bit act);
    return {act, 13'd0, dn, u, 16'(d)};
  endfunction

  function automatic longint unit_adj(input bit u, input bit dn);
    if (u) return longint'(ROLL);
    return dn ? -1 : 1;
  endfunction

  // run one full adjustment and check length, done and net time
  task automatic run_adj(input int d, input bit u, input bit dn, input int per, input string req);
    int n = 0;
    int eff = (per < 2) ? 1 : per;
    wr(2'd1, 32'(per));
    wr(2'd0, cmd(d, u, dn, 1'b1));
    while (active_o && n < 100000) begin n++; @(negedge clk_i); end
    adj += longint'(d) * unit_adj(u, dn);
    check(n == d * eff, {req, " active length"}, n, d * eff);
    check(done_o == 1'b1, {req, " done set"}, done_o, 1);
    check_time({req, " time"});
    wr(2'd2, 32'd1);
    check(done_o == 1'b0, "R10 done cleared", done_o, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(sec_o == 0 && ns_o == 0, "R1 time", longint'(ns_o), 0);
    check(!active_o && !done_o && !step_up_o && !step_dn_o, "R1 flags",
          longint'({active_o, done_o, step_up_o, step_dn_o}), 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    check_time("R2 free run");
    repeat (2600) @(negedge clk_i);
    check(sec_o == 1, "R2 carry", longint'(sec_o), 1);
    check_time("R2 wrap");

    // R3 / R6 ns add, spacing 0
    run_adj(25, 1'b0, 1'b0, 0, "R3 R6");
    // R4 subtract, spacing 1, and per-clock delta
    begin
      longint a, b;
      wr(2'd1, 32'd1);
      wr(2'd0, cmd(3, 1'b0, 1'b1, 1'b1));
      a = longint'(ns_o);
      @(negedge clk_i);
      b = longint'(ns_o);
      check(((b - a + ROLL) % ROLL) == NOM - 1, "R4 dn step delta", (b - a + ROLL) % ROLL, NOM - 1);
      check(step_dn_o && !step_up_o, "R4 dn strobe", longint'(step_dn_o), 1);
      repeat (3) @(negedge clk_i);
      adj -= 3;
      check_time("R4 net");
      check(done_o, "R9 done after dn run", done_o, 1);
      wr(2'd2, 32'd1);
    end
    // R7 spacing 100
    run_adj(25, 1'b0, 1'b1, 100, "R7");
    // R5 seconds ignore direction
    run_adj(2, 1'b1, 1'b1, 3, "R5");

    // R8 spacing write mid-run has no effect
    begin
      int n = 1;
      wr(2'd1, 32'd3);
      wr(2'd0, cmd(4, 1'b0, 1'b0, 1'b1));
      wr(2'd1, 32'd1);
      while (active_o && n < 1000) begin n++; @(negedge clk_i); end
      adj += 4;
      check(n == 12, "R8 captured spacing", n, 12);
      check_time("R8 time");
    end

    // R10 new start does not clear done
    check(done_o, "R9 done set", done_o, 1);
    wr(2'd1, 32'd0);
    wr(2'd0, cmd(3, 1'b0, 1'b0, 1'b1));
    check(done_o, "R10 done kept on start", done_o, 1);
    repeat (3) @(negedge clk_i);
    adj += 3;
    check(!active_o, "R9 run ended", active_o, 0);
    wr(2'd2, 32'd1);
    check(!done_o, "R10 W1C", done_o, 0);

    // R11 abort with start=0 after 6 steps
    wr(2'd0, cmd(20, 1'b0, 1'b0, 1'b1));
    repeat (5) @(negedge clk_i);
    wr(2'd0, cmd(20, 1'b0, 1'b0, 1'b0));
    adj += 6;
    check(!active_o && !done_o, "R11 abort idle", longint'({active_o, done_o}), 0);
    repeat (4) @(negedge clk_i);
    check_time("R11 abort time");

    // R11 restart after 5 steps with a 7 ns subtract
    begin
      int n = 0;
      wr(2'd0, cmd(20, 1'b0, 1'b0, 1'b1));
      repeat (4) @(negedge clk_i);
      wr(2'd0, cmd(7, 1'b0, 1'b1, 1'b1));
      while (active_o && n < 1000) begin n++; @(negedge clk_i); end
      adj += 5 - 7;
      check(n == 7, "R11 restart length", n, 7);
      check(done_o, "R11 restart done", done_o, 1);
      check_time("R11 restart time");
      wr(2'd2, 32'd1);
    end

    // R12 zero count
    wr(2'd0, cmd(0, 1'b0, 1'b0, 1'b1));
    check(done_o && !active_o, "R12 zero count", longint'({done_o, active_o}), 2);
    @(negedge clk_i);
    check_time("R12 no step");
    wr(2'd2, 32'd1);

    // random mix
    for (int i = 0; i < 20; i++) begin
      int d = int'($urandom_range(1, 60));
      bit u = ($urandom_range(0, 3) == 0);
      bit dn = 1'($urandom);
      int per = int'($urandom_range(0, 5));
      run_adj(d, u, dn, per, "R3 random");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule